// File: doc/BRIEF.md
# Three-Phase 31-Level Staircase Gate Pattern Generator

This block produces the thirty gate commands for a three-phase inverter whose phase voltage is a staircase of 31 levels, from -15 to +15 steps. A free-running position counter covers one output period of `CYCLE` clocks. Fifteen switching-angle counts, all inside the first quarter of the period, are compared against a folded copy of that position. Folding in time gives the falling half of the positive lobe, and negating the level gives the negative lobe. Phases B and C read the same pattern at the position minus a fixed offset, so they lag by a third and two thirds of the period.

Each signed level is encoded into five upper-switch commands: four magnitude bits and one polarity bit. Every command drives a complementary pair, and a per-pair dead-time unit holds both gates of a pair low for `DEAD` clocks before either side turns on. The angle table is written through a small write port while the block is idle. A control state machine checks the table when `en` rises. The states are IDLE, CHECK, HOLD, RUN and FAULT. IDLE goes to CHECK when `en` is high. CHECK goes to HOLD when the table passes, or to FAULT when it does not. HOLD goes to RUN after `DEAD` clocks. RUN goes to FAULT when a level decodes to an illegal code. Every state except IDLE returns to IDLE when `en` drops.

Top module: `mli_gate_gen`

## Requirements
- R1: While `rst` is high, and from the second clock after `en` is sampled low, all 30 gates are low and `lvl_a_o`, `lvl_b_o`, `lvl_c_o` and `pos_o` are zero.
- R2: In RUN, `pos_o` advances by one each clock and returns to 0 after `CYCLE-1`.
- R3: `lvl_a_o` equals the number of table entries less than or equal to the folded position f, negated when `pos_o` is at least CYCLE/2. Here r is `pos_o` modulo CYCLE/2, f = r when r < CYCLE/4, and f = CYCLE/2-1-r otherwise.
- R4: `lvl_b_o` and `lvl_c_o` follow the rule of R3 at position (`pos_o` - `OFF_B`) and (`pos_o` - `OFF_C`) modulo `CYCLE`.
- R5: For a settled level, the upper command of pair k (k = 0..3) is bit k of the level's magnitude, and the upper command of pair 4 is 1 exactly when the level is negative. A level whose code reads as negative zero or out of range sends the block to FAULT.
- R6: The upper switch of pair k in phase p (A=0, B=1, C=2) is `gate_o[10p+2k]` and its lower partner is `gate_o[10p+2k+1]`. Once settled, the lower gate is the complement of the upper gate.
- R7: The two gates of a pair are never high in the same clock.
- R8: A gate rises only after both gates of its pair have been low for at least `DEAD` consecutive clocks.
- R9: A table write takes effect only in IDLE and only for an index below 15. Writes in any other state are ignored.
- R10: A table that is not strictly increasing, or whose last entry is not below CYCLE/4, leads to FAULT. In FAULT all gates stay low and all levels stay zero until `en` drops.
- R11: After `en` rises, no gate goes high before `DEAD` clocks have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run request; low forces all gates off |
| wr_en | input | 1 | Angle table write strobe (IDLE only) |
| wr_idx | input | IW | Angle index 0..14 |
| wr_cnt | input | CW | Angle value in clock counts |
| gate_o | output | 30 | Gate commands, pair k of phase p at bits 10p+2k (upper) and 10p+2k+1 (lower) |
| lvl_a_o | output | LW | Signed present level of phase A |
| lvl_b_o | output | LW | Signed present level of phase B |
| lvl_c_o | output | LW | Signed present level of phase C |
| pos_o | output | CW | Cycle position to which the levels belong |

## Verification
Several properties are checked on every cycle: pair exclusivity, the dead-time gap before any rising gate, the late start after enable, the position step and wrap, the sign of phase A in each half, and the gates being cleared after a disable. Only the bench scenarios can show that the levels follow the staircase rule at every position of a full period, including the 120° offsets, the quarter and half mirroring, and the end-of-table boundary. The same holds for the settled switch encoding, for writes being ignored outside IDLE, and for the two table faults keeping everything low.

// File: rtl/mli_pkg.sv
package mli_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_HOLD,
        ST_RUN,
        ST_FAULT
    } mli_state_e;
endpackage

// File: rtl/mli_phase_level.sv
// Staircase level of one phase from its cycle position and the angle table.
module mli_phase_level #(
    parameter int CYCLE = 1_000_000,
    parameter int N_ANG = 15,
    parameter int CW    = 20,
    parameter int LW    = 5
) (
    input  logic [CW-1:0]        pos_i,
    input  logic [CW-1:0]        tbl_i [N_ANG],
    output logic signed [LW-1:0] lvl_o
);
    localparam int HALF    = CYCLE / 2;
    localparam int QUARTER = CYCLE / 4;

    logic          neg;
    logic [CW-1:0] rel;
    logic [CW-1:0] fold;
    logic [LW-1:0] steps;

    always_comb begin
        neg   = (pos_i >= CW'(HALF));
        rel   = neg ? (pos_i - CW'(HALF)) : pos_i;
        fold  = (rel < CW'(QUARTER)) ? rel : (CW'(HALF - 1) - rel);
        steps = '0;
        for (int i = 0; i < N_ANG; i++) begin
            if (tbl_i[i] <= fold) begin
                steps = steps + LW'(1);
            end
        end
        lvl_o = neg ? -$signed(steps) : $signed(steps);
    end
endmodule

// File: rtl/mli_level_decode.sv
// Signed level to upper-switch commands: magnitude bits, then polarity.
module mli_level_decode #(
    parameter int LW    = 5,
    parameter int PAIRS = 5
) (
    input  logic signed [LW-1:0] lvl_i,
    output logic [PAIRS-1:0]     up_o,
    output logic                 illegal_o
);
    logic          neg;
    logic [LW-1:0] abs_v;

    always_comb begin
        neg       = lvl_i[LW-1];
        abs_v     = neg ? LW'(-lvl_i) : LW'(lvl_i);
        up_o      = {neg, abs_v[LW-2:0]};
        illegal_o = neg && ((abs_v[LW-2:0] == '0) || abs_v[LW-1]);
    end
endmodule

// File: rtl/mli_deadtime.sv
// One complementary pair with a guaranteed all-off gap before any turn-on.
module mli_deadtime #(
    parameter int DEAD = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic cmd_i,
    output logic hi_o,
    output logic lo_o
);
    localparam int DW = $clog2(DEAD + 1);

    logic          hi_q, lo_q, hi_d, lo_d;
    logic [DW-1:0] idle_q, idle_d;

    always_comb begin
        hi_d = hi_q;
        lo_d = lo_q;
        if (!active_i) begin
            hi_d = 1'b0;
            lo_d = 1'b0;
        end else if (hi_q && !cmd_i) begin
            hi_d = 1'b0;
        end else if (lo_q && cmd_i) begin
            lo_d = 1'b0;
        end else if (!hi_q && !lo_q && (idle_q == DW'(DEAD))) begin
            hi_d = cmd_i;
            lo_d = !cmd_i;
        end
        if (hi_d || lo_d) begin
            idle_d = '0;
        end else if (idle_q == DW'(DEAD)) begin
            idle_d = idle_q;
        end else begin
            idle_d = idle_q + DW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= 1'b0;
            lo_q   <= 1'b0;
            idle_q <= '0;
        end else begin
            hi_q   <= hi_d;
            lo_q   <= lo_d;
            idle_q <= idle_d;
        end
    end

    assign hi_o = hi_q;
    assign lo_o = lo_q;
endmodule

// File: rtl/mli_gate_gen.sv
// Three-phase staircase gate pattern generator with table check and dead time.
module mli_gate_gen
    import mli_pkg::*;
#(
    parameter int CYCLE   = 1_000_000,
    parameter int N_ANG   = 15,
    parameter int DEAD    = 200,
    parameter int OFF_B   = 333_333,
    parameter int OFF_C   = 666_667,
    localparam int CW     = $clog2(CYCLE),
    localparam int IW     = $clog2(N_ANG),
    localparam int LW     = $clog2(N_ANG + 1) + 1,
    localparam int PAIRS  = LW,
    localparam int GW     = 3 * 2 * PAIRS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  logic [CW-1:0]        wr_cnt,
    output logic [GW-1:0]        gate_o,
    output logic signed [LW-1:0] lvl_a_o,
    output logic signed [LW-1:0] lvl_b_o,
    output logic signed [LW-1:0] lvl_c_o,
    output logic [CW-1:0]        pos_o
);
    localparam int QUARTER = CYCLE / 4;
    localparam int HW      = $clog2(DEAD + 1);
    localparam int OFFS [3] = '{0, OFF_B, OFF_C};

    mli_state_e st_q, st_d;

    logic [CW-1:0]        tbl_q [N_ANG];
    logic [IW-1:0]        chk_q, chk_nxt;
    logic [HW-1:0]        hold_q;
    logic [CW-1:0]        cnt_q;
    logic                 chk_last, chk_fail, hold_done;
    logic                 running, illegal_any, gates_active;
    logic [CW-1:0]        ph_pos [3];
    logic signed [LW-1:0] ph_lvl [3];
    logic signed [LW-1:0] lvl_q  [3];
    logic [PAIRS-1:0]     ph_up  [3];
    logic [2:0]           ph_bad;

    // table scan during CHECK
    always_comb begin
        chk_last  = (chk_q == IW'(N_ANG - 1));
        chk_nxt   = chk_last ? chk_q : (chk_q + IW'(1));
        chk_fail  = chk_last ? (tbl_q[chk_q] >= CW'(QUARTER))
                             : (tbl_q[chk_q] >= tbl_q[chk_nxt]);
        hold_done = (hold_q == HW'(DEAD - 1));
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (en) st_d = ST_CHECK;
            ST_CHECK: begin
                if (!en)           st_d = ST_IDLE;
                else if (chk_fail) st_d = ST_FAULT;
                else if (chk_last) st_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!en)            st_d = ST_IDLE;
                else if (hold_done) st_d = ST_RUN;
            end
            ST_RUN: begin
                if (!en)              st_d = ST_IDLE;
                else if (illegal_any) st_d = ST_FAULT;
            end
            ST_FAULT: if (!en) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // table, scan index, hold timer and cycle counter
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ANG; i++) begin
                tbl_q[i] <= CW'((i + 1) * QUARTER / (N_ANG + 1));
            end
            chk_q  <= '0;
            hold_q <= '0;
            cnt_q  <= '0;
        end else begin
            if ((st_q == ST_IDLE) && wr_en && (wr_idx < IW'(N_ANG))) begin
                tbl_q[wr_idx] <= wr_cnt;
            end
            chk_q  <= (st_q == ST_CHECK) ? chk_nxt : '0;
            hold_q <= (st_q == ST_HOLD) ? (hold_q + HW'(1)) : '0;
            if (st_q != ST_RUN)               cnt_q <= '0;
            else if (cnt_q == CW'(CYCLE - 1)) cnt_q <= '0;
            else                              cnt_q <= cnt_q + CW'(1);
        end
    end

    assign running      = (st_q == ST_RUN);
    assign illegal_any  = |ph_bad;
    assign gates_active = running && !illegal_any;

    genvar p, k;
    generate
        for (p = 0; p < 3; p++) begin : g_phase
            if (p == 0) begin : g_ref
                assign ph_pos[p] = cnt_q;
            end else begin : g_lag
                assign ph_pos[p] = (cnt_q >= CW'(OFFS[p])) ? (cnt_q - CW'(OFFS[p]))
                                                          : (cnt_q + CW'(CYCLE - OFFS[p]));
            end

            mli_phase_level #(.CYCLE(CYCLE), .N_ANG(N_ANG), .CW(CW), .LW(LW)) u_level (
                .pos_i (ph_pos[p]),
                .tbl_i (tbl_q),
                .lvl_o (ph_lvl[p])
            );

            mli_level_decode #(.LW(LW), .PAIRS(PAIRS)) u_decode (
                .lvl_i     (lvl_q[p]),
                .up_o      (ph_up[p]),
                .illegal_o (ph_bad[p])
            );

            for (k = 0; k < PAIRS; k++) begin : g_pair
                mli_deadtime #(.DEAD(DEAD)) u_dt (
                    .clk      (clk),
                    .rst      (rst),
                    .active_i (gates_active),
                    .cmd_i    (ph_up[p][k]),
                    .hi_o     (gate_o[p*2*PAIRS + 2*k]),
                    .lo_o     (gate_o[p*2*PAIRS + 2*k + 1])
                );
            end
        end
    endgenerate

    // registered level and position outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 3; i++) lvl_q[i] <= '0;
            pos_o <= '0;
        end else begin
            for (int i = 0; i < 3; i++) lvl_q[i] <= running ? ph_lvl[i] : '0;
            pos_o <= running ? cnt_q : '0;
        end
    end

    assign lvl_a_o = lvl_q[0];
    assign lvl_b_o = lvl_q[1];
    assign lvl_c_o = lvl_q[2];
endmodule

// File: rtl/mli_gate_gen_chk.sv
module mli_gate_gen_chk #(
    parameter int CYCLE = 1_000_000,
    parameter int N_ANG = 15,
    parameter int DEAD  = 200,
    parameter int CW    = 20,
    parameter int LW    = 5,
    parameter int GW    = 30
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 en,
    input logic [GW-1:0]        gate_o,
    input logic signed [LW-1:0] lvl_a_o,
    input logic [CW-1:0]        pos_o
);
    localparam int NP   = GW / 2;
    localparam int DW   = $clog2(DEAD + 1);
    localparam int HALF = CYCLE / 2;

    logic [NP-1:0] hi_v, lo_v;
    logic [DW-1:0] en_cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)             en_cnt <= '0;
        else if (en_cnt != DW'(DEAD)) en_cnt <= en_cnt + DW'(1);
    end

    genvar k;
    generate
        for (k = 0; k < NP; k++) begin : g_pair
            logic [DW-1:0] low_cnt;
            assign hi_v[k] = gate_o[2*k];
            assign lo_v[k] = gate_o[2*k+1];

            always_ff @(posedge clk) begin
                if (rst || hi_v[k] || lo_v[k]) low_cnt <= '0;
                else if (low_cnt != DW'(DEAD)) low_cnt <= low_cnt + DW'(1);
            end

            AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
                ($rose(hi_v[k]) || $rose(lo_v[k])) |-> (low_cnt >= DW'(DEAD)))
                else $error("dead-time gap too short on pair %0d", k); // R8
        end
    endgenerate

    AST_PAIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (hi_v & lo_v) == '0)
        else $error("pair with both gates high"); // R7

    AST_OFF_AFTER_DISABLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> ##1 ((gate_o == '0) && (pos_o == '0)))
        else $error("gates still on after disable"); // R1

    AST_POS_WRAP: assert property (@(posedge clk) disable iff (rst)
        (pos_o == CW'(CYCLE - 1)) |=> (pos_o == '0))
        else $error("position did not wrap"); // R2

    AST_POS_STEP: assert property (@(posedge clk) disable iff (rst)
        (pos_o != '0) && (pos_o != CW'(CYCLE - 1)) |=>
        ((pos_o == $past(pos_o) + CW'(1)) || (pos_o == '0)))
        else $error("position skipped"); // R2

    AST_FIRST_HALF_NONNEG: assert property (@(posedge clk) disable iff (rst)
        (pos_o < CW'(HALF)) |-> !lvl_a_o[LW-1])
        else $error("negative level in positive half"); // R3

    AST_SECOND_HALF_NONPOS: assert property (@(posedge clk) disable iff (rst)
        (pos_o >= CW'(HALF)) |-> (lvl_a_o[LW-1] || (lvl_a_o == '0)))
        else $error("positive level in negative half"); // R3

    AST_NO_EARLY_GATE: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && (gate_o != '0)) |-> (en_cnt >= DW'(DEAD)))
        else $error("gate on too soon after enable"); // R11
endmodule

bind mli_gate_gen mli_gate_gen_chk #(
    .CYCLE (CYCLE),
    .N_ANG (N_ANG),
    .DEAD  (DEAD),
    .CW    (CW),
    .LW    (LW),
    .GW    (GW)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .gate_o  (gate_o),
    .lvl_a_o (lvl_a_o),
    .pos_o   (pos_o)
);

// File: tb/mli_gate_gen_test.sv
module mli_gate_gen_test;
    localparam int CYC = 240, NA = 15, DT = 2, OB = 80, OC = 160;
    localparam int CW = 8, IW = 4, LW = 5, PR = 5, GW = 30;

    logic clk = 1'b0, rst = 1'b1, en = 1'b0, wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [CW-1:0] wr_cnt = '0;
    logic [GW-1:0] gate;
    logic signed [LW-1:0] la, lb, lc;
    logic [CW-1:0] pos;

    int n_chk = 0, n_fail = 0;
    int tbl [NA];
    int mode = 0;
    string mreq = "R1";
    int prev_pos = -1;
    int stab [3] = '{0, 0, 0};
    int prev_l [3] = '{0, 0, 0};
    int low_cnt [15];
    logic [GW-1:0] prev_g = '0;

    always #5 clk = ~clk;

    mli_gate_gen #(.CYCLE(CYC), .N_ANG(NA), .DEAD(DT), .OFF_B(OB), .OFF_C(OC)) uut (
        .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_idx(wr_idx), .wr_cnt(wr_cnt),
        .gate_o(gate), .lvl_a_o(la), .lvl_b_o(lb), .lvl_c_o(lc), .pos_o(pos)
    );

    function automatic int ref_lvl(int p);
        int r, f, c;
        bit neg;
        neg = (p >= CYC / 2);
        r = neg ? p - CYC / 2 : p;
        f = (r < CYC / 4) ? r : CYC / 2 - 1 - r;
        c = 0;
        for (int i = 0; i < NA; i++) if (tbl[i] <= f) c++;
        return neg ? -c : c;
    endfunction

    function automatic int wrapm(int p);
        return ((p % CYC) + CYC) % CYC;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int idx, int val);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_cnt = CW'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    // per-cycle monitor
    always @(negedge clk) begin
        if (!rst) begin
            int lv [3];
            lv[0] = la; lv[1] = lb; lv[2] = lc;
            for (int k = 0; k < 15; k++) begin
                logic hi, lo;
                hi = gate[2*k]; lo = gate[2*k+1];
                check(!(hi && lo), "R7", {hi, lo}, 0);
                if (hi && !prev_g[2*k])   check(low_cnt[k] >= DT, "R8", low_cnt[k], DT);
                if (lo && !prev_g[2*k+1]) check(low_cnt[k] >= DT, "R8", low_cnt[k], DT);
                low_cnt[k] = (hi || lo) ? 0 : low_cnt[k] + 1;
            end
            prev_g = gate;
            for (int p = 0; p < 3; p++) begin
                stab[p] = (lv[p] == prev_l[p]) ? stab[p] + 1 : 0;
                prev_l[p] = lv[p];
            end
            if (mode == 1) begin
                if (prev_pos >= 0) check(int'(pos) == (prev_pos + 1) % CYC, "R2", pos, (prev_pos + 1) % CYC);
                prev_pos = pos;
                check(lv[0] == ref_lvl(pos), "R3", lv[0], ref_lvl(pos));
                check(lv[1] == ref_lvl(wrapm(pos - OB)), "R4", lv[1], ref_lvl(wrapm(pos - OB)));
                check(lv[2] == ref_lvl(wrapm(pos - OC)), "R4", lv[2], ref_lvl(wrapm(pos - OC)));
                for (int p = 0; p < 3; p++) begin
                    if (stab[p] >= DT + 1) begin
                        int m;
                        logic [PR-1:0] e;
                        m = (lv[p] < 0) ? -lv[p] : lv[p];
                        e = {lv[p] < 0, m[3:0]};
                        for (int k = 0; k < PR; k++) begin
                            check(gate[p*2*PR + 2*k] == e[k], "R5", gate[p*2*PR + 2*k], e[k]);
                            check(gate[p*2*PR + 2*k + 1] == !e[k], "R6", gate[p*2*PR + 2*k + 1], !e[k]);
                        end
                    end
                end
            end else if (mode == 2) begin
                check(gate == '0, mreq, gate, 0);
                check(la == 0 && lb == 0 && lc == 0 && pos == 0, mreq, pos, 0);
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end actual=hung expected=done");
        finish_run();
    end

    initial begin
        int n;
        for (int i = 0; i < 15; i++) low_cnt[i] = 0;
        for (int i = 0; i < NA; i++) tbl[i] = 4 * i + 2;
        wait_n(4);
        // R1: reset state
        check(gate == '0 && la == 0 && lb == 0 && lc == 0 && pos == 0, "R1", gate, 0);
        rst = 1'b0;
        for (int i = 0; i < NA; i++) wr(i, tbl[i]);

        // R11: late first gate after enable
        @(negedge clk); en = 1'b1;
        n = 0;
        while (gate == '0 && n < 200) begin @(negedge clk); n++; end
        check(n >= DT, "R11", n, DT);
        wait_n(20);
        prev_pos = -1; mode = 1;
        wait_n(2 * CYC);

        // R9: write while running must be ignored
        wr(0, 50);
        wait_n(CYC);

        // R1: disable clears everything
        mode = 0; en = 1'b0;
        wait_n(3);
        mreq = "R1"; mode = 2;
        wait_n(10);
        mode = 0;

        // R9: re-enable with unchanged table
        en = 1'b1;
        wait_n(40);
        prev_pos = -1; mode = 1;
        wait_n(CYC);
        mode = 0; en = 1'b0;
        wait_n(3);

        // R10: equal neighbours
        wr(5, 18);
        en = 1'b1;
        wait_n(40);
        mreq = "R10"; mode = 2;
        wait_n(300);
        mode = 0; en = 1'b0;
        wait_n(3);

        // R10: last entry at quarter boundary
        wr(5, 22);
        wr(14, 60);
        en = 1'b1;
        wait_n(40);
        mreq = "R10"; mode = 2;
        wait_n(300);
        mode = 0; en = 1'b0;
        wait_n(3);

        // R3: last entry one below the quarter is accepted
        wr(14, 59);
        tbl[14] = 59;
        en = 1'b1;
        wait_n(40);
        prev_pos = -1; mode = 1;
        wait_n(CYC + 5);
        mode = 0;
        finish_run();
    end
endmodule